// File: doc/BRIEF.md
# Paired Accumulator Arithmetic Unit with Condition Flags

This block is the data path of a small 8-bit execution core. It holds two 8-bit accumulators, called high and low. Some operations treat them as a single 16-bit word, with the high accumulator as the upper byte. A caller presents an operation code and an operand, then raises `op_valid` for one clock. On that edge the selected accumulator or accumulators are written. The 8-bit condition register is updated on the same edge.

The unit covers several operation types: byte loads, byte add with and without carry-in, add low-to-high, subtract, compare, rotate-left through carry, and a 16-bit load and add on the pair. It also has a direct load of the whole condition register. The condition register keeps its bit positions fixed, from bit 7 down to bit 0: stop-disable, X-mask, half-carry H, I-mask, negative N, zero Z, overflow V, carry C. The three control bits (stop-disable, X-mask and I-mask) are only held. Arithmetic never changes them.

Top module: `dacc_unit`

## Requirements
- R1: While reset is asserted, and on the first edge after it, both accumulators read 0 and the condition register reads 8'hD0, with the stop-disable, X-mask and I-mask bits set.
- R2: Operation codes are 0 load-high, 1 load-low, 2 add-high, 3 add-high-with-carry, 4 add-low-to-high, 5 subtract-high, 6 compare-high, 7 rotate-high, 8 load-pair, 9 add-pair and 10 load-condition. The byte operand is `operand[7:0]`. Results appear on the edge where `op_valid` is high.
- R3: The pair output `acc_d` always equals {high, low}. Load-pair and add-pair write `operand`-based results to both accumulators.
- R4: Add-high, add-with-carry and add-low-to-high set H to the carry out of bit 3 and clear it otherwise. All other operations leave H unchanged.
- R5: For byte additions C is the carry out of bit 7. For subtract and compare, C is the borrow, meaning it is set when the high accumulator is less than the operand as an unsigned number.
- R6: V is set on signed overflow. For additions this means both operands have the same sign and the result has the other sign. For subtraction and compare this means the operands differ in sign and the result's sign differs from the minuend's.
- R7: N equals the result's top bit and Z is set when the result is zero. This holds for byte and pair results alike.
- R8: Compare updates N, Z, V and C but writes no accumulator.
- R9: Rotate shifts the high accumulator left, with C entering bit 0 and bit 7 leaving into C. V is then set to N XOR C.
- R10: Byte loads and load-pair clear V and leave C and H unchanged.
- R11: Pair operations compute N, Z and V on the 16-bit result. For add-pair, C is the carry out of bit 15.
- R12: Load-condition writes `operand[7:0]` to the whole condition register. No other operation changes the stop-disable, X-mask or I-mask bits.
- R13: Changes occur only when `op_valid` is high. Codes 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Execute the presented operation on this edge |
| op_code | input | 4 | Operation select |
| operand | input | 16 | Operand data; byte operations use bits 7:0 |
| acc_hi | output | 8 | High accumulator |
| acc_lo | output | 8 | Low accumulator |
| acc_d | output | 16 | Pair view {acc_hi, acc_lo} |
| ccr | output | 8 | Condition register |

## Verification
The arithmetic is driven through a chained sequence of operands.

The add cases are kept apart from one another:
- A nibble-boundary carry with no byte carry isolates H.
- Two positives giving a negative, and two negatives wrapping to zero, separate V from C and Z.
- A carry-in of one into a zero sum confirms that add-with-carry really uses C.

The subtract cases show that borrow and overflow are independent:
- A small-minus-larger pair gives a borrow without overflow.
- A negative-minus-positive pair gives overflow without a borrow.

Compare with equal values must set Z while leaving the accumulator untouched. Rotations run with C both clear and set. After the condition register is cleared, the later cases show that arithmetic leaves the control bits alone and keeps H.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LD_HI  = 4'd0,
    OP_LD_LO  = 4'd1,
    OP_ADD_HI = 4'd2,
    OP_ADC_HI = 4'd3,
    OP_ADD_LH = 4'd4,
    OP_SUB_HI = 4'd5,
    OP_CMP_HI = 4'd6,
    OP_ROL_HI = 4'd7,
    OP_LD_PR  = 4'd8,
    OP_ADD_PR = 4'd9,
    OP_LD_CC  = 4'd10
  } op_e;

  // condition register bit positions
  localparam int CC_S = 7;
  localparam int CC_X = 6;
  localparam int CC_H = 5;
  localparam int CC_I = 4;
  localparam int CC_N = 3;
  localparam int CC_Z = 2;
  localparam int CC_V = 1;
  localparam int CC_C = 0;

  localparam logic [BYTE_W-1:0] CC_RESET = 8'hD0;
endpackage

// File: rtl/dacc_rst_sync.sv
module dacc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1] & rst_n;
endmodule

// File: rtl/dacc_alu.sv
module dacc_alu
  import dacc_pkg::*;
(
  input  logic [OP_W-1:0]   op_code,
  input  logic [WORD_W-1:0] operand,
  input  logic [BYTE_W-1:0] hi,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] cc,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic              wr_cc,
  output logic [BYTE_W-1:0] hi_nxt,
  output logic [BYTE_W-1:0] lo_nxt,
  output logic [BYTE_W-1:0] cc_nxt
);
  localparam int NIB_W = BYTE_W / 2;

  op_e                op;
  logic [BYTE_W-1:0]  m8;
  logic               cin;
  logic [BYTE_W:0]    sum9;
  logic [NIB_W:0]     nib_sum;
  logic [BYTE_W:0]    dif9;
  logic [WORD_W:0]    sum17;
  logic [BYTE_W-1:0]  r8;
  logic [WORD_W-1:0]  r16;

  always_comb begin
    op      = op_e'(op_code);
    m8      = (op == OP_ADD_LH) ? lo : operand[BYTE_W-1:0];
    cin     = (op == OP_ADC_HI) ? cc[CC_C] : 1'b0;
    sum9    = {1'b0, hi} + {1'b0, m8} + {{BYTE_W{1'b0}}, cin};
    nib_sum = {1'b0, hi[NIB_W-1:0]} + {1'b0, m8[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    dif9    = {1'b0, hi} - {1'b0, m8};
    sum17   = {1'b0, hi, lo} + {1'b0, operand};
  end

  always_comb begin
    wr_hi  = 1'b0;
    wr_lo  = 1'b0;
    wr_cc  = 1'b1;
    hi_nxt = hi;
    lo_nxt = lo;
    cc_nxt = cc;
    r8     = '0;
    r16    = '0;
    case (op)
      OP_LD_HI, OP_LD_LO: begin
        r8 = operand[BYTE_W-1:0];
        if (op == OP_LD_HI) begin wr_hi = 1'b1; hi_nxt = r8; end
        else                begin wr_lo = 1'b1; lo_nxt = r8; end
        cc_nxt[CC_N] = r8[BYTE_W-1];
        cc_nxt[CC_Z] = (r8 == '0);
        cc_nxt[CC_V] = 1'b0;
      end
      OP_ADD_HI, OP_ADC_HI, OP_ADD_LH: begin
        r8     = sum9[BYTE_W-1:0];
        wr_hi  = 1'b1;
        hi_nxt = r8;
        cc_nxt[CC_H] = nib_sum[NIB_W];
        cc_nxt[CC_N] = r8[BYTE_W-1];
        cc_nxt[CC_Z] = (r8 == '0);
        cc_nxt[CC_V] = (hi[BYTE_W-1] == m8[BYTE_W-1]) && (r8[BYTE_W-1] != hi[BYTE_W-1]);
        cc_nxt[CC_C] = sum9[BYTE_W];
      end
      OP_SUB_HI, OP_CMP_HI: begin
        r8 = dif9[BYTE_W-1:0];
        if (op == OP_SUB_HI) begin wr_hi = 1'b1; hi_nxt = r8; end
        cc_nxt[CC_N] = r8[BYTE_W-1];
        cc_nxt[CC_Z] = (r8 == '0);
        cc_nxt[CC_V] = (hi[BYTE_W-1] != m8[BYTE_W-1]) && (r8[BYTE_W-1] != hi[BYTE_W-1]);
        cc_nxt[CC_C] = dif9[BYTE_W];
      end
      OP_ROL_HI: begin
        r8     = {hi[BYTE_W-2:0], cc[CC_C]};
        wr_hi  = 1'b1;
        hi_nxt = r8;
        cc_nxt[CC_N] = r8[BYTE_W-1];
        cc_nxt[CC_Z] = (r8 == '0);
        cc_nxt[CC_C] = hi[BYTE_W-1];
        cc_nxt[CC_V] = r8[BYTE_W-1] ^ hi[BYTE_W-1];
      end
      OP_LD_PR, OP_ADD_PR: begin
        r16    = (op == OP_LD_PR) ? operand : sum17[WORD_W-1:0];
        wr_hi  = 1'b1;
        wr_lo  = 1'b1;
        hi_nxt = r16[WORD_W-1:BYTE_W];
        lo_nxt = r16[BYTE_W-1:0];
        cc_nxt[CC_N] = r16[WORD_W-1];
        cc_nxt[CC_Z] = (r16 == '0);
        if (op == OP_LD_PR) begin
          cc_nxt[CC_V] = 1'b0;
        end else begin
          cc_nxt[CC_V] = (hi[BYTE_W-1] == operand[WORD_W-1]) && (r16[WORD_W-1] != hi[BYTE_W-1]);
          cc_nxt[CC_C] = sum17[WORD_W];
        end
      end
      OP_LD_CC: cc_nxt = operand[BYTE_W-1:0];
      default:  wr_cc = 1'b0;
    endcase
  end
endmodule

// File: rtl/dacc_regs.sv
module dacc_regs
  import dacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_hi,
  input  logic              en_lo,
  input  logic              en_cc,
  input  logic [BYTE_W-1:0] hi_nxt,
  input  logic [BYTE_W-1:0] lo_nxt,
  input  logic [BYTE_W-1:0] cc_nxt,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] cc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      cc_q <= CC_RESET;
    end else begin
      if (en_hi) hi_q <= hi_nxt;
      if (en_lo) lo_q <= lo_nxt;
      if (en_cc) cc_q <= cc_nxt;
    end
  end

  // R13
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_hi || en_lo || en_cc) |=> ($stable(hi_q) && $stable(lo_q) && $stable(cc_q)));
endmodule

// File: rtl/dacc_unit.sv
module dacc_unit
  import dacc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_code,
  input  logic [15:0] operand,
  output logic [7:0]  acc_hi,
  output logic [7:0]  acc_lo,
  output logic [15:0] acc_d,
  output logic [7:0]  ccr
);
  logic              rst_n_s;
  logic              wr_hi, wr_lo, wr_cc;
  logic [BYTE_W-1:0] hi_nxt, lo_nxt, cc_nxt;

  dacc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  dacc_alu u_alu (
    .op_code(op_code), .operand(operand), .hi(acc_hi), .lo(acc_lo), .cc(ccr),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_cc(wr_cc),
    .hi_nxt(hi_nxt), .lo_nxt(lo_nxt), .cc_nxt(cc_nxt)
  );

  dacc_regs u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .en_hi(op_valid & wr_hi), .en_lo(op_valid & wr_lo), .en_cc(op_valid & wr_cc),
    .hi_nxt(hi_nxt), .lo_nxt(lo_nxt), .cc_nxt(cc_nxt),
    .hi_q(acc_hi), .lo_q(acc_lo), .cc_q(ccr)
  );

  assign acc_d = {acc_hi, acc_lo};

  // R8
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && op_code == OP_CMP_HI) |=> ($stable(acc_hi) && $stable(acc_lo)));

  // R10
  load_clears_v_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && (op_code == OP_LD_HI || op_code == OP_LD_LO || op_code == OP_LD_PR))
    |=> (!ccr[CC_V] && $stable(ccr[CC_C]) && $stable(ccr[CC_H])));

  // R12
  ctrl_bits_held_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(op_valid && op_code == OP_LD_CC) |=> ($stable(ccr[CC_S]) && $stable(ccr[CC_X]) && $stable(ccr[CC_I])));

  // R4
  h_held_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && (op_code == OP_SUB_HI || op_code == OP_CMP_HI || op_code == OP_ROL_HI || op_code == OP_ADD_PR))
    |=> $stable(ccr[CC_H]));

  // R9
  rol_carry_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && op_code == OP_ROL_HI) |=> (ccr[CC_C] == $past(acc_hi[BYTE_W-1]) && acc_hi[0] == $past(ccr[CC_C])));

  // R7
  load_zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && op_code == OP_LD_HI) |=> (ccr[CC_Z] == (acc_hi == '0) && ccr[CC_N] == acc_hi[BYTE_W-1]));
endmodule

// File: tb/sim_dacc_unit.sv
module sim_dacc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [15:0] operand = '0;
  logic [7:0]  acc_hi, acc_lo, ccr;
  logic [15:0] acc_d;
  int n_cmp = 0;
  int n_bad = 0;

  dacc_unit u0 (.*);

  always #10 clk = ~clk;

  // {op, operand, exp_hi, exp_lo, exp_ccr, requirement tag}
  localparam int NV = 19;
  localparam logic [51:0] VEC [NV] = '{
    {4'd0,  16'h000F, 8'h0F, 8'h00, 8'hD0, 8'd10}, // R10 load
    {4'd1,  16'h0001, 8'h0F, 8'h01, 8'hD0, 8'd2},  // R2 load low
    {4'd4,  16'h0000, 8'h10, 8'h01, 8'hF0, 8'd4},  // R4 H on nibble carry
    {4'd2,  16'h0070, 8'h80, 8'h01, 8'hDA, 8'd6},  // R6 pos+pos overflow
    {4'd3,  16'h0080, 8'h00, 8'h01, 8'hD7, 8'd5},  // R5 carry, zero, V
    {4'd3,  16'h0000, 8'h01, 8'h01, 8'hD0, 8'd5},  // R5 carry-in used
    {4'd5,  16'h0002, 8'hFF, 8'h01, 8'hD9, 8'd5},  // R5 borrow
    {4'd6,  16'h00FF, 8'hFF, 8'h01, 8'hD4, 8'd8},  // R8 compare equal
    {4'd7,  16'h0000, 8'hFE, 8'h01, 8'hD9, 8'd9},  // R9 rotate C=0
    {4'd7,  16'h0000, 8'hFD, 8'h01, 8'hD9, 8'd9},  // R9 rotate C=1
    {4'd8,  16'h8000, 8'h80, 8'h00, 8'hD9, 8'd3},  // R3 load pair
    {4'd9,  16'h8000, 8'h00, 8'h00, 8'hD7, 8'd11}, // R11 carry out bit 15
    {4'd9,  16'h1234, 8'h12, 8'h34, 8'hD0, 8'd11}, // R11 plain add
    {4'd10, 16'h0000, 8'h12, 8'h34, 8'h00, 8'd12}, // R12 load condition
    {4'd2,  16'h000E, 8'h20, 8'h34, 8'h20, 8'd4},  // R4 H set
    {4'd5,  16'h0030, 8'hF0, 8'h34, 8'h29, 8'd4},  // R4 H kept on sub
    {4'd5,  16'h007F, 8'h71, 8'h34, 8'h22, 8'd6},  // R6 neg-pos overflow
    {4'd1,  16'h0000, 8'h71, 8'h00, 8'h24, 8'd7},  // R7 zero
    {4'd15, 16'hFFFF, 8'h71, 8'h00, 8'h24, 8'd13}  // R13 unused code
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [15:0] d, input logic v);
    @(negedge clk);
    op_code  = c;
    operand  = d;
    op_valid = v;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hi", acc_hi, 8'h00);
    check("R1 lo", acc_lo, 8'h00);
    check("R1 ccr", ccr, 8'hD0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ccr after release", ccr, 8'hD0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][51:48], VEC[i][47:32], 1'b1);
      check($sformatf("R%0d vec%0d hi", VEC[i][7:0], i), acc_hi, VEC[i][31:24]);
      check($sformatf("R%0d vec%0d lo", VEC[i][7:0], i), acc_lo, VEC[i][23:16]);
      check($sformatf("R%0d vec%0d ccr", VEC[i][7:0], i), ccr, VEC[i][15:8]);
      check("R3 pair view", acc_d, {acc_hi, acc_lo});
    end

    // R13: op_valid low means no change
    apply(4'd0, 16'h0055, 1'b0);
    check("R13 idle hi", acc_hi, 8'h71);
    check("R13 idle ccr", ccr, 8'h24);

    // R12: control bits survive arithmetic after being set
    apply(4'd10, 16'h00D0, 1'b1);
    apply(4'd2, 16'h0001, 1'b1);
    check("R12 ctrl kept", ccr & 8'hD0, 8'hD0);
    check("R2 add result", acc_hi, 8'h72);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid hi", acc_hi, 8'h00);
    check("R1 mid ccr", ccr, 8'hD0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule